// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit sits beside the fetch and decode stages of a thread-interleaved pipeline. It keeps a bank of down-counting timers for every hardware thread. Whenever a thread owns a fetch slot, each running timer of that thread counts down by one. A thread that has no slot leaves its timers unchanged.

A deadline instruction sets a lower bound on how long a block of code takes. When decode presents one, the unit looks at the addressed timer. If the timer is still running, the unit raises a stall flag and the pipeline replays the same instruction on that thread's next turn. If the timer has reached zero, the unit loads the timer with the instruction's immediate and the thread continues. The result is that the instruction waits until the previous deadline has run out and then sets the next one in the same step.

A separate read port returns any timer's value so that the pipeline can read timers as register operands.

Top module: `deadline_timer_unit`

## Requirements
- R1: When `dl_valid` is high and the addressed timer (`dl_tid`, `dl_idx`) is nonzero, `dl_stall` is 1 in the cycle after the decode cycle.
- R2: When `dl_valid` is high and the addressed timer is zero, the timer holds `dl_imm` after the clock edge, and `dl_stall` is 0 in the next cycle.
- R3: On each cycle with `slot_valid` high, every nonzero timer of thread `slot_tid` decreases by exactly one.
- R4: Timers of threads other than `slot_tid`, and all timers in cycles with `slot_valid` low, keep their values.
- R5: A stalled deadline instruction leaves its timer's value unchanged. Replaying it keeps stalling until the timer is zero, and the replay after that loads the timer.
- R6: Timers saturate at zero: a slot never decrements a timer that is already zero.
- R7: When a load and a slot decrement fall on the same timer in the same cycle, the timer takes `dl_imm` and no decrement is applied. The thread's other timers still decrement.
- R8: A deadline immediate of 0 loads zero, so the next deadline instruction on that timer passes with no stall.
- R9: A synchronous active-high `rst` clears every timer to zero and clears `dl_stall`.
- R10: `rd_value` shows, one cycle later, the value timer (`rd_tid`, `rd_idx`) held before the clock edge. Defaults: 4 threads, 8 timers per thread, 32-bit timers, 3-bit timer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | Fetch slot is occupied this cycle |
| slot_tid | input | TID_W | Thread that owns the fetch slot |
| dl_valid | input | 1 | A deadline instruction is in decode |
| dl_tid | input | TID_W | Thread of the deadline instruction |
| dl_idx | input | IDX_W | Timer addressed by the instruction |
| dl_imm | input | TIMER_W | Immediate deadline value |
| rd_tid | input | TID_W | Thread for the read port |
| rd_idx | input | IDX_W | Timer for the read port |
| dl_stall | output | 1 | Registered stall and replay request |
| rd_value | output | TIMER_W | Registered timer read value |

## Verification
Timer updates take effect at the clock edge that ends the stimulus cycle. `dl_stall` and `rd_value` are both registered, so each of them reports, one edge later, a decision taken on the state the timers held before that edge. The bench drives inputs on the falling edge and computes the expected stall and read values from a reference model before it advances the model. It then samples the outputs one time unit after the next rising edge. This keeps each check aligned to the single register stage between the stimulus and the result.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int unsigned DTU_THREADS = 4;
  localparam int unsigned DTU_TIMERS  = 8;
  localparam int unsigned DTU_WIDTH   = 32;
endpackage

// File: rtl/dtu_timer_cell.sv
module dtu_timer_cell #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  input  logic         dec,
  input  logic [W-1:0] imm,
  output logic [W-1:0] q
);
  logic at_zero;
  assign at_zero = (q == '0);

  always_ff @(posedge clk) begin
    if (rst)                q <= '0;
    else if (hit && at_zero) q <= imm;
    else if (dec && !at_zero) q <= q - 1'b1;
  end

  // R2 / R7: a load wins over a decrement
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    (hit && at_zero) |=> (q == $past(imm)));
  // R3: decrement by one
  a_r3_dec_one: assert property (@(posedge clk) disable iff (rst)
    (dec && !hit && !at_zero) |=> (q == $past(q) - 1'b1));
  // R6: saturate at zero
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (at_zero && !hit) |=> (q == '0));
  // R5: a stalled deadline leaves the timer untouched unless its thread has a slot
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (hit && !at_zero && !dec) |=> $stable(q));
  // R9: reset clears
  a_r9_reset: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/dtu_thread_bank.sv
module dtu_thread_bank #(
  parameter int unsigned NTIMERS = 8,
  parameter int unsigned W       = 32,
  localparam int unsigned IDX_W  = $clog2(NTIMERS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel,
  input  logic [IDX_W-1:0]              idx,
  input  logic [W-1:0]                  imm,
  input  logic                          dec,
  output logic [NTIMERS-1:0][W-1:0]     q
);
  for (genvar i = 0; i < NTIMERS; i++) begin : g_cell
    logic hit_i;
    assign hit_i = sel && (idx == IDX_W'(i));
    dtu_timer_cell #(.W(W)) cell_i (
      .clk (clk),
      .rst (rst),
      .hit (hit_i),
      .dec (dec),
      .imm (imm),
      .q   (q[i])
    );
  end
endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
  parameter int unsigned NTHREADS = dtu_pkg::DTU_THREADS,
  parameter int unsigned NTIMERS  = dtu_pkg::DTU_TIMERS,
  parameter int unsigned TIMER_W  = dtu_pkg::DTU_WIDTH,
  localparam int unsigned TID_W   = $clog2(NTHREADS),
  localparam int unsigned IDX_W   = $clog2(NTIMERS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_valid,
  input  logic [TID_W-1:0]   slot_tid,
  input  logic               dl_valid,
  input  logic [TID_W-1:0]   dl_tid,
  input  logic [IDX_W-1:0]   dl_idx,
  input  logic [TIMER_W-1:0] dl_imm,
  input  logic [TID_W-1:0]   rd_tid,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               dl_stall,
  output logic [TIMER_W-1:0] rd_value
);
  logic [NTHREADS-1:0][NTIMERS-1:0][TIMER_W-1:0] bank_q;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
    logic sel_t, dec_t;
    assign sel_t = dl_valid && (dl_tid == TID_W'(t));
    assign dec_t = slot_valid && (slot_tid == TID_W'(t));
    dtu_thread_bank #(.NTIMERS(NTIMERS), .W(TIMER_W)) bank_i (
      .clk (clk),
      .rst (rst),
      .sel (sel_t),
      .idx (dl_idx),
      .imm (dl_imm),
      .dec (dec_t),
      .q   (bank_q[t])
    );
  end

  logic [TIMER_W-1:0] addr_q;
  assign addr_q = bank_q[dl_tid][dl_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_stall <= 1'b0;
      rd_value <= '0;
    end else begin
      dl_stall <= dl_valid && (addr_q != '0);
      rd_value <= bank_q[rd_tid][rd_idx];
    end
  end

  // R1: busy timer forces a stall next cycle
  a_r1_stall_busy: assert property (@(posedge clk) disable iff (rst)
    (dl_valid && addr_q != '0) |=> dl_stall);
  // R2: expired timer lets the instruction pass and takes the immediate
  a_r2_pass_load: assert property (@(posedge clk) disable iff (rst)
    (dl_valid && addr_q == '0) |=> (!dl_stall && bank_q[$past(dl_tid)][$past(dl_idx)] == $past(dl_imm)));
  // R1: no decode, no stall
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !dl_valid |=> !dl_stall);
endmodule

// File: tb/deadline_timer_unit_tb.sv
module deadline_timer_unit_tb_top;
  localparam int NT = 4, NI = 8, W = 32;
  localparam time PERIOD = 10;

  logic clk = 0, rst = 1;
  logic slot_valid = 0, dl_valid = 0;
  logic [1:0] slot_tid = 0, dl_tid = 0, rd_tid = 0;
  logic [2:0] dl_idx = 0, rd_idx = 0;
  logic [W-1:0] dl_imm = 0;
  logic dl_stall;
  logic [W-1:0] rd_value;

  int total = 0, bad = 0;
  logic [W-1:0] model [NT][NI];

  always #(PERIOD/2) clk = ~clk;

  deadline_timer_unit dut_i (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_tid(slot_tid),
    .dl_valid(dl_valid), .dl_tid(dl_tid), .dl_idx(dl_idx), .dl_imm(dl_imm),
    .rd_tid(rd_tid), .rd_idx(rd_idx), .dl_stall(dl_stall), .rd_value(rd_value)
  );

  task automatic step(input bit sv, input int st, input bit dv, input int dt,
                      input int di, input logic [W-1:0] imm,
                      input int rt, input int ri, input string tag);
    logic exp_stall;
    logic [W-1:0] exp_rd;
    @(negedge clk);
    slot_valid = sv; slot_tid = st[1:0];
    dl_valid = dv; dl_tid = dt[1:0]; dl_idx = di[2:0]; dl_imm = imm;
    rd_tid = rt[1:0]; rd_idx = ri[2:0];
    exp_stall = dv && (model[dt][di] != 0);
    exp_rd = model[rt][ri];
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) begin
        if (dv && t == dt && i == di && model[t][i] == 0) model[t][i] = imm;
        else if (sv && t == st && model[t][i] != 0) model[t][i] = model[t][i] - 1;
      end
    @(posedge clk); #1;
    total += 2;
    if (dl_stall !== exp_stall) begin
      bad++;
      $display("FAIL %s stall actual=%0b expected=%0b", tag, dl_stall, exp_stall);
    end
    if (rd_value !== exp_rd) begin
      bad++;
      $display("FAIL %s rd t%0d i%0d actual=%0d expected=%0d", tag, rt, ri, rd_value, exp_rd);
    end
  endtask

  task automatic sweep(input string tag);
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++)
        step(0, 0, 0, 0, 0, 0, t, i, tag);
  endtask

  initial begin
    #(PERIOD*150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) model[t][i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R9: reset state, R10 read port
    sweep("R9_reset");
    // R2: load every timer with a distinct value; also R10 read-back
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++)
        step(0, 0, 1, t, i, W'(t*8 + i + 3), t, i, "R2_load");
    sweep("R10_readback");
    // R3 / R4: round-robin slots, plus idle cycles
    for (int k = 0; k < 12; k++) step(1, k % NT, 0, 0, 0, 0, k % NT, k % NI, "R3_dec");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 1, k, "R4_idle");
    for (int k = 0; k < 6; k++) step(1, 2, 0, 0, 0, 0, 3, k, "R4_other_thread");
    sweep("R4_sweep");
    // R1 / R5: replay on thread 3 timer 7 until expired, alternating slots
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 1, 3, 7, 32'd5, 3, 7, "R1_R5_replay");
      step(1, 3, 0, 0, 0, 0, 3, 7, "R5_slot");
    end
    // R6: drive thread 0 far past zero
    for (int k = 0; k < 20; k++) step(1, 0, 0, 0, 0, 0, 0, k % NI, "R6_saturate");
    sweep("R6_sweep");
    // R8: zero immediate passes, then passes again
    step(0, 0, 1, 0, 2, 32'd0, 0, 2, "R8_zero_imm");
    step(0, 0, 1, 0, 2, 32'd0, 0, 2, "R8_zero_again");
    step(0, 0, 1, 0, 2, 32'hFFFF_FFFF, 0, 2, "R8_then_load");
    step(0, 0, 1, 0, 2, 32'd1, 0, 2, "R1_busy_max");
    // R7: load and slot of same thread in the same cycle
    step(1, 0, 1, 0, 5, 32'd9, 0, 5, "R7_load_wins");
    step(0, 0, 0, 0, 0, 0, 0, 5, "R7_check");
    step(1, 0, 1, 0, 5, 32'd9, 0, 2, "R7_busy_dec");
    sweep("R7_sweep");
    // R9: reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++) model[t][i] = 0;
    sweep("R9_midrun");
    step(0, 0, 1, 1, 1, 32'd2, 1, 1, "R9_stall_clear");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule